// File: doc/BRIEF.md
# FM Hard-Sector Write Formatter

This block produces the full serial FM cell stream for one hard sector of a floppy track. A sector index pulse that arrives while the block is idle starts a sector. The block takes the cylinder and sector numbers from its inputs at that moment. It then emits one FM cell per cell-time strobe until the sector length is reached. Each data bit becomes a clock cell of 1 followed by the data cell, with the most significant bit first.

The sector has a fixed layout. It opens with a long run of zero bytes and the sync word 0x00 0x01. A two-byte address field follows, then a short run of zero bytes, a second 0x00 0x01 sync, and 512 payload bytes. The payload is pulled one byte at a time through a request/valid port. After the payload come a 16-bit CRC and zero fill up to the sector length. The sector length is derived at elaboration time from the revolution time, the bit time and the number of sectors per revolution.

If the payload source has no byte ready when one is needed, the block sends a zero byte in its place and raises a sticky underrun flag. This keeps the cell timing intact.

Top module: `fm_sector_writer`

## Requirements
- R1: After reset, `busy`, `cell_valid`, `underrun` and `byte_req` are all 0.
- R2: When `index_pulse` is high at a clock edge while `busy` is 0, a sector starts and `busy` is 1 from the next cycle. After that, `cell_valid` is high for exactly one cycle after each edge at which `cell_strobe` was high and `busy` was 1. It is never high after an edge without a strobe.
- R3: Every byte is sent as 16 cells. Each of its bits, MSB first, becomes a clock cell of 1 followed by a cell equal to the bit.
- R4: Byte layout by offset k. Bytes 0..43 are 0x00. Bytes 44 and 45 are 0x00 and 0x01. Bytes 48..52 are 0x00. Bytes 53 and 54 are 0x00 and 0x01. Bytes 569 up to the end of the sector are 0x00.
- R5: Byte 46 is the cylinder number ANDed with 0x07. Byte 47 is (sector number AND 0x0F) shifted left by 2. Both values are taken from the inputs at the edge that accepts the index pulse, and later changes on the inputs have no effect.
- R6: Bytes 567 and 568 are the high and low bytes of a CRC over the 512 payload bytes. The CRC uses generator x^16+x^8+1 (0x0101), processes bits MSB first, and starts from 0 at the first payload byte.
- R7: The sector is SECTOR_BYTES = 166000/2/N_SECTORS/16 bytes long (integer division), which is 648 bytes or 10368 cells for N_SECTORS = 8.
- R8: Bytes 55..566 are the payload. `byte_req` is high in exactly 512 cycles per sector. A byte is taken from `byte_data` in a cycle where both `byte_req` and `byte_valid` are high.
- R9: In a cycle with `byte_req` high and `byte_valid` low, the payload byte becomes 0x00 and `underrun` is set. `underrun` stays set until the next accepted index pulse clears it.
- R10: `busy` falls at the edge that emits the last fill cell. Index pulses while `busy` is 1 are ignored and do not change the stream or its length. While idle, no cells are emitted even when strobes arrive.
- R11: An index pulse in the cycle right after `busy` falls starts the next sector normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| index_pulse | input | 1 | Sector index pulse; starts a sector when idle |
| cell_strobe | input | 1 | One cell time elapsed; emit the next cell |
| cyl_num | input | CYL_W | Cylinder number |
| sec_num | input | SEC_W | Sector number |
| byte_req | output | 1 | Payload byte taken this cycle |
| byte_data | input | 8 | Payload byte from the source |
| byte_valid | input | 1 | Source has a byte on `byte_data` |
| cell_out | output | 1 | Current FM cell |
| cell_valid | output | 1 | `cell_out` holds a new cell this cycle |
| busy | output | 1 | Sector in progress |
| underrun | output | 1 | Sticky: a payload byte was replaced by zero |

## Verification
The bench uses irregular strobes and stretches where the source is not valid. A design that stalls on a missing byte instead of substituting zero would show up as a wrong cell count and as shifted payload bytes. Cylinder and sector inputs change on every cycle of a sector, so taking them at the wrong moment corrupts bytes 46 and 47. Index pulses land in the middle of sectors, and a design that restarts on them would give a short or garbled sector. The last sector starts in the cycle right after `busy` falls. This checks that the underrun flag clears and that no cell from the finished sector leaks into the next.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

    typedef enum logic [2:0] {
        PH_GAP1,
        PH_SYNC1,
        PH_ADDR,
        PH_GAP2,
        PH_SYNC2,
        PH_DATA,
        PH_CRC,
        PH_FILL
    } phase_e;

    localparam int CNT_W          = 16;
    localparam int CELLS_PER_BYTE = 16;
    localparam int LEAD_ZEROS     = 44;
    localparam int MID_ZEROS      = 5;
    localparam int SYNC_LEN       = 2;
    localparam int ADDR_LEN       = 2;
    localparam int PAYLOAD_LEN    = 512;
    localparam int CRC_LEN        = 2;
    localparam int HEAD_LEN       = LEAD_ZEROS + SYNC_LEN + ADDR_LEN + MID_ZEROS
                                  + SYNC_LEN + PAYLOAD_LEN + CRC_LEN;
    localparam logic [15:0] SYNC_WORD = 16'h0001;
    localparam logic [15:0] CRC_GEN   = 16'h0101;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
    } pos_t;

    function automatic int sector_len(int rev_us, int bit_us, int nsec);
        return rev_us / bit_us / nsec / 16;
    endfunction

    function automatic int phase_len(phase_e p, int fill);
        case (p)
            PH_GAP1:  return LEAD_ZEROS;
            PH_SYNC1: return SYNC_LEN;
            PH_ADDR:  return ADDR_LEN;
            PH_GAP2:  return MID_ZEROS;
            PH_SYNC2: return SYNC_LEN;
            PH_DATA:  return PAYLOAD_LEN;
            PH_CRC:   return CRC_LEN;
            default:  return fill;
        endcase
    endfunction

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_GAP1:  return PH_SYNC1;
            PH_SYNC1: return PH_ADDR;
            PH_ADDR:  return PH_GAP2;
            PH_GAP2:  return PH_SYNC2;
            PH_SYNC2: return PH_DATA;
            PH_DATA:  return PH_CRC;
            PH_CRC:   return PH_FILL;
            default:  return PH_GAP1;
        endcase
    endfunction

    function automatic logic [7:0] addr_byte(logic second, logic [15:0] cyl, logic [15:0] sec);
        if (second)
            return {2'b00, sec[3:0], 2'b00};
        return {5'b00000, cyl[2:0]};
    endfunction

    function automatic logic [15:0] crc_byte(logic [15:0] cur, logic [7:0] din);
        logic [15:0] r;
        r = cur;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ din[i];
            r  = {r[14:0], 1'b0};
            if (fb)
                r = r ^ CRC_GEN;
        end
        return r;
    endfunction

endpackage

// File: rtl/fmw_crc16.sv
module fmw_crc16
    import fmw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        first,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk) begin
        if (rst)
            crc <= 16'h0000;
        else if (en)
            crc <= crc_byte(first ? 16'h0000 : crc, din);
    end

    // R6
    crc_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (en && first && din != 8'h00) |=> (crc != 16'h0000));

endmodule

// File: rtl/fmw_cell_shifter.sv
module fmw_cell_shifter
    import fmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       strobe,
    input  logic       active,
    input  logic       load_en,
    input  logic [7:0] load_byte,
    output logic       byte_done,
    output logic       cell_out,
    output logic       cell_valid
);

    localparam int IDX_W = $clog2(CELLS_PER_BYTE);

    logic [7:0]       sh_q;
    logic [IDX_W-1:0] idx_q;

    assign byte_done = strobe && active && (idx_q == IDX_W'(CELLS_PER_BYTE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q       <= 8'h00;
            idx_q      <= '0;
            cell_out   <= 1'b0;
            cell_valid <= 1'b0;
        end else begin
            cell_valid <= 1'b0;
            if (start) begin
                sh_q  <= 8'h00;
                idx_q <= '0;
            end else if (strobe && active) begin
                cell_valid <= 1'b1;
                if (!idx_q[0]) begin
                    cell_out <= 1'b1;
                end else begin
                    cell_out <= sh_q[7];
                    sh_q     <= {sh_q[6:0], 1'b0};
                end
                idx_q <= idx_q + 1'b1;
                if (byte_done && load_en)
                    sh_q <= load_byte;
            end
        end
    end

    // R3
    clock_cell_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && active && !idx_q[0]) |=> (cell_valid && cell_out));

    // R2
    cell_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cell_valid |-> ($past(strobe) && $past(active)));

endmodule

// File: rtl/fmw_sequencer.sv
module fmw_sequencer
    import fmw_pkg::*;
#(
    parameter int FILL_LEN = 79,
    parameter int CYL_W    = 8,
    parameter int SEC_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adv,
    input  logic [CYL_W-1:0] cyl_in,
    input  logic [SEC_W-1:0] sec_in,
    input  logic [7:0]       byte_data,
    input  logic             byte_valid,
    input  logic [15:0]      crc,
    output logic             busy,
    output logic             underrun,
    output logic             byte_req,
    output logic             load_en,
    output logic [7:0]       load_byte,
    output logic             crc_first
);

    localparam phase_e LAST_PHASE = (FILL_LEN > 0) ? PH_FILL : PH_CRC;

    pos_t             cur, nxt;
    logic             end_of_phase;
    logic             is_last;
    logic [CYL_W-1:0] cyl_q;
    logic [SEC_W-1:0] sec_q;

    assign end_of_phase = (cur.cnt == CNT_W'(phase_len(cur.phase, FILL_LEN) - 1));
    assign is_last      = end_of_phase && (cur.phase == LAST_PHASE);

    always_comb begin
        nxt = cur;
        if (end_of_phase) begin
            nxt.phase = phase_after(cur.phase);
            nxt.cnt   = '0;
        end else begin
            nxt.cnt = cur.cnt + 1'b1;
        end
    end

    assign load_en   = adv && busy && !is_last;
    assign byte_req  = load_en && (nxt.phase == PH_DATA);
    assign crc_first = byte_req && (nxt.cnt == '0);

    always_comb begin
        case (nxt.phase)
            PH_SYNC1, PH_SYNC2:
                load_byte = (nxt.cnt == '0) ? SYNC_WORD[15:8] : SYNC_WORD[7:0];
            PH_ADDR:
                load_byte = addr_byte(nxt.cnt[0], 16'(cyl_q), 16'(sec_q));
            PH_DATA:
                load_byte = byte_valid ? byte_data : 8'h00;
            PH_CRC:
                load_byte = (nxt.cnt == '0) ? crc[15:8] : crc[7:0];
            default:
                load_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            underrun <= 1'b0;
            cur      <= '{phase: PH_GAP1, cnt: '0};
            cyl_q    <= '0;
            sec_q    <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            underrun <= 1'b0;
            cur      <= '{phase: PH_GAP1, cnt: '0};
            cyl_q    <= cyl_in;
            sec_q    <= sec_in;
        end else if (adv && busy) begin
            if (is_last)
                busy <= 1'b0;
            else
                cur <= nxt;
            if (byte_req && !byte_valid)
                underrun <= 1'b1;
        end
    end

    // R9
    underrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (underrun && !start) |=> underrun);

    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cur.phase == LAST_PHASE));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> ($stable(cyl_q) && $stable(sec_q)));

    // R8
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        byte_req |-> busy);

endmodule

// File: rtl/fm_sector_writer.sv
module fm_sector_writer
    import fmw_pkg::*;
#(
    parameter int N_SECTORS = 8,
    parameter int REV_US    = 166000,
    parameter int BIT_US    = 2,
    parameter int CYL_W     = 8,
    parameter int SEC_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             index_pulse,
    input  logic             cell_strobe,
    input  logic [CYL_W-1:0] cyl_num,
    input  logic [SEC_W-1:0] sec_num,
    output logic             byte_req,
    input  logic [7:0]       byte_data,
    input  logic             byte_valid,
    output logic             cell_out,
    output logic             cell_valid,
    output logic             busy,
    output logic             underrun
);

    localparam int SECTOR_LEN = sector_len(REV_US, BIT_US, N_SECTORS);
    localparam int FILL_LEN   = (SECTOR_LEN > HEAD_LEN) ? SECTOR_LEN - HEAD_LEN : 0;

    logic        start;
    logic        byte_done;
    logic        load_en;
    logic [7:0]  load_byte;
    logic        crc_first;
    logic [15:0] crc;

    assign start = index_pulse && !busy;

    fmw_sequencer #(
        .FILL_LEN (FILL_LEN),
        .CYL_W    (CYL_W),
        .SEC_W    (SEC_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .adv        (byte_done),
        .cyl_in     (cyl_num),
        .sec_in     (sec_num),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .crc        (crc),
        .busy       (busy),
        .underrun   (underrun),
        .byte_req   (byte_req),
        .load_en    (load_en),
        .load_byte  (load_byte),
        .crc_first  (crc_first)
    );

    fmw_cell_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .strobe     (cell_strobe),
        .active     (busy),
        .load_en    (load_en),
        .load_byte  (load_byte),
        .byte_done  (byte_done),
        .cell_out   (cell_out),
        .cell_valid (cell_valid)
    );

    fmw_crc16 u_crc (
        .clk   (clk),
        .rst   (rst),
        .first (crc_first),
        .en    (byte_req),
        .din   (load_byte),
        .crc   (crc)
    );

    // R10
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && index_pulse && !byte_done) |=> busy);

endmodule

// File: tb/fm_sector_writer_bench.sv
module fm_sector_writer_bench;

    localparam int NSEC    = 8;
    localparam int SB      = 166000 / 2 / NSEC / 16;
    localparam int NCELLS  = SB * 16;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       index_pulse = 1'b0;
    logic       cell_strobe = 1'b0;
    logic [7:0] cyl_num = 8'h00;
    logic [7:0] sec_num = 8'h00;
    logic [7:0] byte_data = 8'h00;
    logic       byte_valid = 1'b0;
    logic       byte_req, cell_out, cell_valid, busy, underrun;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [7:0] src      [0:512];
    logic [7:0] exp_data [0:511];
    logic       cellbuf  [0:16383];

    always #10 clk = ~clk;

    fm_sector_writer #(.N_SECTORS(NSEC)) u_fm_sector_writer (
        .clk, .rst, .index_pulse, .cell_strobe, .cyl_num, .sec_num,
        .byte_req, .byte_data, .byte_valid, .cell_out, .cell_valid,
        .busy, .underrun
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc();
        logic [16:0] r;
        logic        b;
        r = '0;
        for (int i = 0; i < 512 * 8 + 16; i++) begin
            b = (i < 4096) ? exp_data[i / 8][7 - (i % 8)] : 1'b0;
            r = {r[15:0], b};
            if (r[16])
                r = r ^ 17'h10101;
        end
        return r[15:0];
    endfunction

    function automatic logic [7:0] exp_byte(int k, logic [7:0] c, logic [7:0] s, logic [15:0] crc);
        if (k == 45 || k == 54) return 8'h01;
        if (k == 46) return {5'b0, c[2:0]};
        if (k == 47) return {2'b0, s[3:0], 2'b0};
        if (k >= 55 && k < 567) return exp_data[k - 55];
        if (k == 567) return crc[15:8];
        if (k == 568) return crc[7:0];
        return 8'h00;
    endfunction

    function automatic logic [7:0] got_byte(int k);
        logic [7:0] v;
        for (int j = 0; j < 8; j++)
            v[7 - j] = cellbuf[16 * k + 2 * j + 1];
        return v;
    endfunction

    task automatic cmp_range(input int lo, input int hi, input string req,
                             input logic [7:0] c, input logic [7:0] s, input logic [15:0] crc);
        int bad, fa, fe;
        bad = 0; fa = 0; fe = 0;
        for (int k = lo; k < hi; k++) begin
            if (got_byte(k) !== exp_byte(k, c, s, crc)) begin
                if (bad == 0) begin
                    fa = int'(got_byte(k));
                    fe = int'(exp_byte(k, c, s, crc));
                end
                bad++;
            end
        end
        check(bad == 0, req, fa, fe);
    endtask

    task automatic run_sector(input logic [7:0] c, input logic [7:0] s,
                              input int ps, input int pv, input int pi);
        logic        exp_under;
        int          nreq, ncell, gate_err, clk_err, ptr;
        logic        prev_str;
        logic [15:0] crc;
        exp_under = 1'b0; nreq = 0; ncell = 0; gate_err = 0; clk_err = 0; ptr = 0;
        for (int i = 0; i < 513; i++) src[i] = 8'($urandom);
        cyl_num = c; sec_num = s; index_pulse = 1'b1; cell_strobe = 1'b0; byte_valid = 1'b0;
        @(negedge clk);
        index_pulse = 1'b0;
        check(busy === 1'b1, "R2 busy after accepted index", int'(busy), 1);
        check(underrun === 1'b0, "R9 underrun cleared by new sector", int'(underrun), 0);
        forever begin
            cell_strobe = (($urandom % 100) < ps);
            byte_valid  = (($urandom % 100) < pv);
            byte_data   = src[ptr];
            index_pulse = (($urandom % 100) < pi);
            cyl_num     = 8'($urandom);
            sec_num     = 8'($urandom);
            #1;
            if (byte_req) begin
                if (nreq < 512) exp_data[nreq] = byte_valid ? src[ptr] : 8'h00;
                if (byte_valid) ptr++;
                else exp_under = 1'b1;
                nreq++;
            end
            prev_str = cell_strobe;
            @(negedge clk);
            if (cell_valid) begin
                if (!prev_str) gate_err++;
                if (ncell < 16384) cellbuf[ncell] = cell_out;
                ncell++;
            end
            if (!busy) break;
        end
        index_pulse = 1'b0;
        cell_strobe = 1'b0;
        check(gate_err == 0, "R2 cell only after strobe", gate_err, 0);
        check(ncell == NCELLS, "R7 R10 cells per sector", ncell, NCELLS);
        check(nreq == 512, "R8 payload requests", nreq, 512);
        check(underrun === exp_under, "R9 underrun flag", int'(underrun), int'(exp_under));
        if (ncell == NCELLS) begin
            for (int i = 0; i < NCELLS; i += 2)
                if (cellbuf[i] !== 1'b1) clk_err++;
            check(clk_err == 0, "R3 clock cells", clk_err, 0);
            crc = ref_crc();
            cmp_range(0, 46, "R4 lead gap and sync", c, s, crc);
            cmp_range(46, 48, "R5 address field", c, s, crc);
            cmp_range(48, 55, "R4 mid gap and sync", c, s, crc);
            cmp_range(55, 567, "R8 R9 payload bytes", c, s, crc);
            cmp_range(567, 569, "R6 crc bytes", c, s, crc);
            cmp_range(569, SB, "R4 zero fill", c, s, crc);
        end
    endtask

    initial begin : watchdog
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        check(1'b0, "watchdog expired", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int quiet;
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        index_pulse = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        index_pulse = 1'b0;
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        check(cell_valid === 1'b0, "R1 cell_valid after reset", int'(cell_valid), 0);
        check(underrun === 1'b0, "R1 underrun after reset", int'(underrun), 0);
        check(byte_req === 1'b0, "R1 byte_req after reset", int'(byte_req), 0);

        // idle strobes emit nothing (R10)
        quiet = 0;
        cell_strobe = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (cell_valid || busy) quiet++;
        end
        cell_strobe = 1'b0;
        check(quiet == 0, "R10 idle strobes produce no cells", quiet, 0);

        // full-rate sector, source always valid
        run_sector(8'h03, 8'h05, 100, 100, 0);
        @(negedge clk);
        // masked address bits, irregular strobes, index pulses while busy
        run_sector(8'hFF, 8'hFF, 60, 100, 5);
        @(negedge clk);
        // starved source, underrun expected
        run_sector(8'h0A, 8'h1B, 100, 70, 0);
        // back-to-back start in the cycle after busy falls (R11)
        run_sector(8'($urandom), 8'($urandom), 80, 100, 2);

        quiet = 0;
        cell_strobe = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (cell_valid || busy) quiet++;
        end
        cell_strobe = 1'b0;
        check(quiet == 0, "R10 R11 quiet after last sector", quiet, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule